// File: doc/BRIEF.md
# Clock Glitch Injection Controller

This block generates the clock fed to a target device during fault-injection experiments. Two clocks enter the block. They run at the same frequency, and the second one lags the first by a fixed phase. The output normally follows the primary clock. Software programs a cycle delay and a glitch length, then arms the block. A trigger input reports that the target has begun its cryptographic computation. After that trigger, the block counts the programmed number of primary cycles. It then hands the output over to the lagging clock for a few cycles and returns it to the primary clock.

The hand-over produces exactly one rising-edge interval shorter than a normal period. Its length equals the lag, and it can violate the target's setup time in a chosen round. The return to the primary clock produces one stretched interval, which is harmless. The controller fires once per arming. It then reports completion and ignores the trigger until software arms it again.

The select register changes only on falling edges of the primary clock. The block therefore requires a lag between half a period and one full period. With such a lag, both sources are low at the moment of each switch, so no runt pulse appears at either transition.

Top module: `glitchClkGen`

## Requirements
- R1: While reset is asserted or the block is not armed, `clkOut` equals `clkPrimary` and every output period equals the primary period, even if `trigIn` toggles.
- R2: Register map (address / content):
  - Address 0 holds the 16-bit delay. Its reset value is 0.
  - Address 1 holds the 4-bit glitch length in data bits 3:0, and bits 15:4 read as 0. Its reset value is 1.
  - A write to address 2 with bit 0 = 1 arms the block, and a write with bit 0 = 0 disarms it.
  - A read of address 2 returns the status: bit 0 = armed or active, bit 1 = counting or glitching, bit 2 = done, and all other bits 0.
- R3: `trigIn` is synchronised on `clkPrimary`. Only a low-to-high transition seen while armed starts the delay. A trigger that is already high when the block is armed starts nothing. A second rising edge during the countdown is ignored.
- R4: With programmed delay D, the output's shortened interval starts at the (D+4)-th primary rising edge after `trigIn` rises. This assumes `trigIn` changes between edges.
- R5: The shortened interval is the only output interval shorter than a primary period, and its length equals the lag of `clkShifted`.
- R6: With length L (0 is treated as 1), the lagging clock supplies L output rising edges. One interval of two periods minus the lag follows, and then the primary clock resumes. No other interval is longer than a period.
- R7: After the glitch, the status reads done = 1 and armed = 0. Further triggers produce no glitch until the block is re-armed, and re-arming clears done.
- R8: Writing 0 to the control bit during the countdown cancels the injection. No glitch follows, and the status returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkPrimary | input | 1 | Primary clock; also clocks all control logic |
| clkShifted | input | 1 | Same-frequency clock lagging the primary by more than half a period |
| rstN | input | 1 | Asynchronous active-low reset |
| trigIn | input | 1 | Asynchronous execution-start trigger |
| regWe | input | 1 | Register write strobe, sampled on `clkPrimary` |
| regAddr | input | 2 | Register address for write and read |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data, combinational from `regAddr` |
| clkOut | output | 1 | Clock delivered to the target |

## Verification
The hardest case to reach from the ports is the placement of the glitch edge relative to the trigger, and the single stretched interval on return. Both exist only as time intervals between rising edges of `clkOut`, not as logic levels. The bench therefore timestamps every output rising edge after it raises the trigger, and it classifies the intervals as short, nominal or stretched. The position and length of the short and stretched intervals are then compared with times computed from the programmed delay, the length and the lag. A re-trigger pulse during the countdown, a trigger that is already high when the block is armed, and a disarm during the countdown are each driven so that they land inside the counting window.

// File: rtl/gcPkg.sv
`timescale 1ns/1ps
package gcPkg;

  localparam int ADDR_W   = 2;
  localparam int STATUS_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_DELAY = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LEN   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd2;

  // status bit positions
  localparam int ST_BIT_ARMED = 0;
  localparam int ST_BIT_BUSY  = 1;
  localparam int ST_BIT_DONE  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_COUNT,
    ST_GLITCH,
    ST_DONE
  } gcState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrDelay;
    logic wrLen;
    logic loadDelay;
    logic decDelay;
    logic loadLen;
    logic decLen;
    logic selAlt;
  } gcStrobe_t;

endpackage

// File: rtl/gcTrigSync.sv
`timescale 1ns/1ps
module gcTrigSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic trigAsync,
  output logic trigRise
);

  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] shReg;
  logic              prevQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) shReg <= '0;
        else       shReg <= trigAsync;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) shReg <= '0;
        else       shReg <= {shReg[STAGES-2:0], trigAsync};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= shReg[TOP];
  end

  assign trigRise = shReg[TOP] & ~prevQ;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    trigRise |=> !trigRise) else $error("double rise pulse"); // R3

endmodule

// File: rtl/gcCtrl.sv
`timescale 1ns/1ps
module gcCtrl
  import gcPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 trigRise,
  input  logic                 regWe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 armBit,
  input  logic                 delayZero,
  input  logic                 lenZero,
  output gcStrobe_t            strobe,
  output logic [STATUS_W-1:0]  status
);

  gcState_e state, stateNxt;
  logic     ctrlWr;
  logic     armReq;
  logic     disarmReq;

  assign ctrlWr    = regWe && (regAddr == ADDR_CTRL);
  assign armReq    = ctrlWr && armBit;
  assign disarmReq = ctrlWr && !armBit;

  always_comb begin
    stateNxt         = state;
    strobe           = '0;
    strobe.wrDelay   = regWe && (regAddr == ADDR_DELAY);
    strobe.wrLen     = regWe && (regAddr == ADDR_LEN);
    strobe.selAlt    = (state == ST_GLITCH);
    unique case (state)
      ST_IDLE: begin
        if (armReq) stateNxt = ST_ARMED;
      end
      ST_ARMED: begin
        if (disarmReq) begin
          stateNxt = ST_IDLE;
        end else if (trigRise) begin
          stateNxt         = ST_COUNT;
          strobe.loadDelay = 1'b1;
        end
      end
      ST_COUNT: begin
        if (disarmReq) begin
          stateNxt = ST_IDLE;
        end else if (delayZero) begin
          stateNxt       = ST_GLITCH;
          strobe.loadLen = 1'b1;
        end else begin
          strobe.decDelay = 1'b1;
        end
      end
      ST_GLITCH: begin
        if (lenZero) stateNxt = ST_DONE;
        else         strobe.decLen = 1'b1;
      end
      ST_DONE: begin
        if (armReq) stateNxt = ST_ARMED;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    status               = '0;
    status[ST_BIT_ARMED] = (state == ST_ARMED) || (state == ST_COUNT) || (state == ST_GLITCH);
    status[ST_BIT_BUSY]  = (state == ST_COUNT) || (state == ST_GLITCH);
    status[ST_BIT_DONE]  = (state == ST_DONE);
  end

  AST_GLITCH_FROM_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_GLITCH) |-> $past(state == ST_COUNT)) else $error("glitch entry"); // R4

  AST_GLITCH_ENDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(state == ST_GLITCH) |-> (state == ST_DONE)) else $error("glitch exit"); // R7

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE && !ctrlWr) |=> (state == ST_DONE)) else $error("done lost"); // R7

  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COUNT && trigRise && !ctrlWr) |=> (state == ST_COUNT || state == ST_GLITCH))
    else $error("retrigger"); // R3

endmodule

// File: rtl/gcDatapath.sv
`timescale 1ns/1ps
module gcDatapath
  import gcPkg::*;
#(
  parameter int DELAY_W = 16,
  parameter int LEN_W   = 4,
  parameter int DATA_W  = 16
) (
  input  logic                 clkPrimary,
  input  logic                 clkShifted,
  input  logic                 rstN,
  input  gcStrobe_t            strobe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  input  logic [STATUS_W-1:0]  statusIn,
  output logic                 delayZero,
  output logic                 lenZero,
  output logic [DATA_W-1:0]    regRdata,
  output logic                 clkOut
);

  localparam logic [DELAY_W-1:0] DELAY_ONE = DELAY_W'(1);
  localparam logic [LEN_W-1:0]   LEN_ONE   = LEN_W'(1);

  logic [DELAY_W-1:0] cfgDelay;
  logic [LEN_W-1:0]   cfgLen;
  logic [DELAY_W-1:0] delayCnt;
  logic [LEN_W-1:0]   lenCnt;
  logic [LEN_W-1:0]   lenStart;
  logic               selQ;

  // configuration registers
  always_ff @(posedge clkPrimary or negedge rstN) begin
    if (!rstN) begin
      cfgDelay <= '0;
      cfgLen   <= LEN_ONE;
    end else begin
      if (strobe.wrDelay) cfgDelay <= regWdata[DELAY_W-1:0];
      if (strobe.wrLen)   cfgLen   <= regWdata[LEN_W-1:0];
    end
  end

  // delay countdown
  always_ff @(posedge clkPrimary or negedge rstN) begin
    if (!rstN)                 delayCnt <= '0;
    else if (strobe.loadDelay) delayCnt <= cfgDelay;
    else if (strobe.decDelay)  delayCnt <= delayCnt - DELAY_ONE;
  end

  assign delayZero = (delayCnt == '0);

  // glitch length countdown, zero length behaves as one
  assign lenStart = (cfgLen == '0) ? '0 : (cfgLen - LEN_ONE);

  always_ff @(posedge clkPrimary or negedge rstN) begin
    if (!rstN)               lenCnt <= '0;
    else if (strobe.loadLen) lenCnt <= lenStart;
    else if (strobe.decLen)  lenCnt <= lenCnt - LEN_ONE;
  end

  assign lenZero = (lenCnt == '0);

  // source select moves only at primary falling edges
  always_ff @(negedge clkPrimary or negedge rstN) begin
    if (!rstN) selQ <= 1'b0;
    else       selQ <= strobe.selAlt;
  end

  assign clkOut = selQ ? clkShifted : clkPrimary;

  // register readback
  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_DELAY: regRdata = DATA_W'(cfgDelay);
      ADDR_LEN:   regRdata = DATA_W'(cfgLen);
      ADDR_CTRL:  regRdata = DATA_W'(statusIn);
      default:    regRdata = '0;
    endcase
  end

  AST_NO_DELAY_UNDERFLOW: assert property (@(posedge clkPrimary) disable iff (!rstN)
    strobe.decDelay |-> (delayCnt != '0)) else $error("delay underflow"); // R4

  AST_NO_LEN_UNDERFLOW: assert property (@(posedge clkPrimary) disable iff (!rstN)
    strobe.decLen |-> (lenCnt != '0)) else $error("length underflow"); // R6

  AST_IDLE_PRIMARY: assert property (@(posedge clkPrimary) disable iff (!rstN)
    !statusIn[ST_BIT_ARMED] |-> !selQ) else $error("select while idle"); // R1

  AST_SEL_HELD_HIGH: assert property (@(posedge clkPrimary) disable iff (!rstN)
    $rose(selQ) |-> statusIn[ST_BIT_BUSY]) else $error("select outside glitch"); // R6

endmodule

// File: rtl/glitchClkGen.sv
`timescale 1ns/1ps
module glitchClkGen #(
  parameter int DELAY_W     = 16,
  parameter int LEN_W       = 4,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clkPrimary,
  input  logic              clkShifted,
  input  logic              rstN,
  input  logic              trigIn,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              clkOut
);

  import gcPkg::*;

  logic                trigRise;
  logic                delayZero;
  logic                lenZero;
  gcStrobe_t           strobe;
  logic [STATUS_W-1:0] status;

  gcTrigSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clkPrimary),
    .rstN      (rstN),
    .trigAsync (trigIn),
    .trigRise  (trigRise)
  );

  gcCtrl u_ctrl (
    .clk       (clkPrimary),
    .rstN      (rstN),
    .trigRise  (trigRise),
    .regWe     (regWe),
    .regAddr   (regAddr),
    .armBit    (regWdata[0]),
    .delayZero (delayZero),
    .lenZero   (lenZero),
    .strobe    (strobe),
    .status    (status)
  );

  gcDatapath #(
    .DELAY_W (DELAY_W),
    .LEN_W   (LEN_W),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clkPrimary (clkPrimary),
    .clkShifted (clkShifted),
    .rstN       (rstN),
    .strobe     (strobe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .statusIn   (status),
    .delayZero  (delayZero),
    .lenZero    (lenZero),
    .regRdata   (regRdata),
    .clkOut     (clkOut)
  );

endmodule

// File: tb/test_glitchClkGen.sv
`timescale 1ns/1ps
module test_glitchClkGen;

  localparam real PER = 8.0;
  localparam real LAG = 5.0;

  logic        clkP = 1'b0;
  logic        clkS = 1'b0;
  logic        rstN = 1'b0;
  logic        trig = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWdata = 16'd0;
  logic [15:0] regRdata;
  logic        clkOut;

  int  total = 0;
  int  bad = 0;
  real logT [256];
  int  logN = 0;
  bit  logOn = 1'b0;

  int  nShort, nLong;
  real shortStart, shortLen, longStart, longLen;

  glitchClkGen i_glitchClkGen (
    .clkPrimary (clkP),
    .clkShifted (clkS),
    .rstN       (rstN),
    .trigIn     (trig),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .clkOut     (clkOut)
  );

  initial forever #4 clkP = ~clkP;
  initial begin
    #5;
    forever #4 clkS = ~clkS;
  end

  always @(posedge clkOut) begin
    if (logOn && logN < 256) begin
      logT[logN] = $realtime;
      logN = logN + 1;
    end
  end

  initial begin
    #1600000;
    bad = bad + 1;
    total = total + 1;
    $display("FAIL watchdog: run did not finish actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic checkInt(string req, string what, int act, int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkReal(string req, string what, real act, real exp);
    total = total + 1;
    if ((act - exp) > 0.01 || (exp - act) > 0.01) begin
      bad = bad + 1;
      $display("FAIL %s %s: actual=%0.3f expected=%0.3f", req, what, act, exp);
    end
  endtask

  task automatic wrReg(logic [1:0] a, logic [15:0] d);
    @(negedge clkP);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clkP);
    regWe = 1'b0;
  endtask

  task automatic rdReg(logic [1:0] a, output logic [15:0] d);
    @(negedge clkP);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic analyze();
    nShort = 0; nLong = 0;
    shortStart = 0.0; shortLen = 0.0; longStart = 0.0; longLen = 0.0;
    for (int i = 1; i < logN; i++) begin
      real d;
      d = logT[i] - logT[i-1];
      if (d < PER - 0.5) begin
        nShort = nShort + 1; shortStart = logT[i-1]; shortLen = d;
      end else if (d > PER + 0.5) begin
        nLong = nLong + 1; longStart = logT[i-1]; longLen = d;
      end
    end
  endtask

  task automatic quietWindow(string req, int cycles);
    @(posedge clkP); #1;
    logN = 0; logOn = 1'b1;
    repeat (cycles) @(posedge clkP);
    #2;
    logOn = 1'b0;
    analyze();
    checkInt(req, "short intervals", nShort, 0);
    checkInt(req, "long intervals", nLong, 0);
    checkInt(req, "edges seen", logN, cycles);
  endtask

  task automatic testReset();
    logic [15:0] v;
    for (int i = 0; i < 6; i++) begin
      #3;
      checkInt("R1", "clkOut in reset", int'(clkOut), int'(clkP));
    end
    rdReg(2'd2, v); checkInt("R2", "status in reset", int'(v), 0);
    rdReg(2'd0, v); checkInt("R2", "delay reset", int'(v), 0);
    rdReg(2'd1, v); checkInt("R2", "length reset", int'(v), 1);
  endtask

  task automatic testRegs();
    logic [15:0] v;
    wrReg(2'd0, 16'hA5C3);
    wrReg(2'd1, 16'hFFF7);
    rdReg(2'd0, v); checkInt("R2", "delay readback", int'(v), 16'hA5C3);
    rdReg(2'd1, v); checkInt("R2", "length readback", int'(v), 7);
    rdReg(2'd2, v); checkInt("R2", "status idle", int'(v), 0);
  endtask

  task automatic testUnarmed();
    logic [15:0] v;
    wrReg(2'd0, 16'd0);
    fork
      begin
        repeat (3) @(posedge clkP); #1 trig = 1'b1;
        repeat (4) @(posedge clkP); #1 trig = 1'b0;
      end
      quietWindow("R1", 30);
    join
    rdReg(2'd2, v); checkInt("R1", "status unarmed", int'(v), 0);
  endtask

  task automatic checkGlitch(string req, int d, int l, bit extra);
    real tRef, tEnd, gExp;
    int  lEff;
    logic [15:0] v;
    lEff = (l == 0) ? 1 : l;
    wrReg(2'd0, 16'(d));
    wrReg(2'd1, 16'(l));
    wrReg(2'd2, 16'd1);
    @(posedge clkP);
    tRef = $realtime;
    #1;
    logN = 0; logOn = 1'b1; trig = 1'b1;
    if (extra) begin
      repeat (3) @(posedge clkP); #1 trig = 1'b0;
      repeat (2) @(posedge clkP); #1 trig = 1'b1;
    end
    tEnd = tRef + (d + lEff + 10) * PER;
    while ($realtime < tEnd) @(posedge clkP);
    #2;
    logOn = 1'b0;
    trig = 1'b0;
    analyze();
    gExp = tRef + (d + 4) * PER;
    checkInt(req, "short count (R5)", nShort, 1);
    checkReal("R4", "short start", shortStart, gExp);
    checkReal("R5", "short length", shortLen, LAG);
    checkInt("R6", "long count", nLong, 1);
    checkReal("R6", "long start", longStart, gExp + (lEff - 1) * PER + LAG);
    checkReal("R6", "long length", longLen, 2.0 * PER - LAG);
    rdReg(2'd2, v); checkInt("R7", "status after glitch", int'(v), 4);
  endtask

  task automatic testNoRetrigger();
    logic [15:0] v;
    fork
      begin
        repeat (2) @(posedge clkP); #1 trig = 1'b1;
        repeat (5) @(posedge clkP); #1 trig = 1'b0;
      end
      quietWindow("R7", 30);
    join
    rdReg(2'd2, v); checkInt("R7", "done held", int'(v), 4);
    wrReg(2'd2, 16'd1);
    rdReg(2'd2, v); checkInt("R7", "rearm clears done", int'(v), 1);
    wrReg(2'd2, 16'd0);
  endtask

  task automatic testHighAtArm();
    logic [15:0] v;
    wrReg(2'd0, 16'd2);
    @(negedge clkP); trig = 1'b1;
    repeat (5) @(posedge clkP);
    wrReg(2'd2, 16'd1);
    quietWindow("R3", 20);
    rdReg(2'd2, v); checkInt("R3", "still armed, no count", int'(v), 1);
    trig = 1'b0;
    wrReg(2'd2, 16'd0);
  endtask

  task automatic testDisarm();
    logic [15:0] v;
    wrReg(2'd0, 16'd30);
    wrReg(2'd1, 16'd3);
    wrReg(2'd2, 16'd1);
    @(posedge clkP); #1 trig = 1'b1;
    repeat (6) @(posedge clkP);
    rdReg(2'd2, v); checkInt("R8", "counting", int'(v), 3);
    wrReg(2'd2, 16'd0);
    quietWindow("R8", 40);
    rdReg(2'd2, v); checkInt("R8", "status after cancel", int'(v), 0);
    trig = 1'b0;
  endtask

  initial begin
    testReset();
    @(negedge clkP); rstN = 1'b1;
    repeat (2) @(posedge clkP);
    testRegs();
    testUnarmed();
    checkGlitch("R4", 0, 1, 1'b0);
    testNoRetrigger();
    checkGlitch("R6", 3, 4, 1'b0);
    checkGlitch("R6", 20, 0, 1'b0);
    checkGlitch("R3", 12, 2, 1'b1);
    testHighAtArm();
    testDisarm();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule